// File: doc/BRIEF.md
# Bit-band alias access bridge

This bridge sits between a bus master and a memory port. The master sees a 32 MB alias window in which every 32-bit alias word stands for a single bit of the backing memory. An alias read comes back as that one bit. An alias write changes only that bit, through a read-modify-write of the backing unit that holds it.

The slave side takes one access at a time: an offset into the window, a size of 1, 2 or 4 bytes, a direction, and write data of which only bit 0 matters. The master side first issues a backing read to the computed physical address. For a write that read succeeds, the master side then issues a write-back of the same unit with the one bit replaced. The slave-side ready pulse comes only after all backing traffic for the access has finished. A fault on either backing access is passed back to the requester. The backing region base is a parameter. Typical instances put backing regions at 0x20000000 and 0x40000000 behind alias windows at 0x22000000 and 0x42000000.

Top module: `bitband_bridge`

## Requirements
- R1: The backing address is BASE OR (offset[24:0] >> 5), with its low bits cleared down to a multiple of the access size. m_size always equals the requested size code.
- R2: The size code is 0 for one byte, 1 for two bytes and 2 for four bytes. Code 3 is refused: s_err is set, s_rdata is zero, and no backing read or write is issued.
- R3: Backing data sits right-justified on m_rdata and m_wdata, with the byte at the lowest address in bits 7:0. The selected bit index is (offset >> 2) AND (8 × bytes − 1).
- R4: A successful read returns the selected backing bit in s_rdata[0] and zero in s_rdata[31:1].
- R5: A write reads the backing unit, then writes the same unit back to the same address and size. In the written unit the selected bit equals s_wdata[0] and every other bit is unchanged.
- R6: If the backing read faults, the access ends with s_err set and s_rdata zero. For a write, no write-back is issued.
- R7: If the write-back faults, the access ends with s_err set.
- R8: s_ready is a one-cycle pulse that comes only after the backing read, and the write-back when there is one, have completed. While m_req waits for m_ready, m_addr and m_we hold steady.
- R9: During and right after reset the bridge is idle: m_req, s_ready and s_err are low.
- R10: Bits 31:1 of s_wdata have no effect on the written unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Alias access request, held until s_ready |
| s_we | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| s_offset | input | 25 | Byte offset inside the alias window |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_ready | output | 1 | One-cycle completion pulse |
| s_err | output | 1 | Completion carries a fault |
| s_rdata | output | 32 | Read result, selected bit in bit 0 |
| m_req | output | 1 | Backing access request, held until m_ready |
| m_we | output | 1 | Backing write when 1 |
| m_size | output | 2 | Backing size code, same encoding as s_size |
| m_addr | output | 32 | Backing byte address, aligned to the size |
| m_wdata | output | 32 | Write-back unit, right-justified |
| m_ready | input | 1 | Backing access complete |
| m_err | input | 1 | Backing access faulted |
| m_rdata | input | 32 | Backing read unit, right-justified |

## Verification
Two events can land in the same cycle: the completion of the backing read and the decision whether a write-back follows. When that read returns a fault during an alias write, the bridge must end the access at once instead of going on to modify. The bench provokes this by writing into a backing range its memory model answers with faults. It then checks that the write counter did not move, that the backing byte is unchanged and that the error reaches the requester. The bench also covers the other ordering, where a clean read is followed by a faulting write-back, and it varies backing latency so that both completions fall at varied distances from the request.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    BB_IDLE   = 3'd0,
    BB_READ   = 3'd1,
    BB_MODIFY = 3'd2,
    BB_WRITE  = 3'd3,
    BB_RESP   = 3'd4
  } bb_state_e;

  localparam logic [1:0] BB_SZ_BAD = 2'd3;

  // Size codes 0..2 are 1, 2 and 4 bytes.
  function automatic logic bb_size_legal(input logic [1:0] sz);
    return (sz != BB_SZ_BAD);
  endfunction

  // Which of the two low address bits survive alignment.
  function automatic logic [1:0] bb_keep_low(input logic [1:0] sz);
    logic [1:0] k;
    case (sz)
      2'd0:    k = 2'b11;
      2'd1:    k = 2'b10;
      default: k = 2'b00;
    endcase
    return k;
  endfunction

  // Bit index mask: 8 * bytes - 1.
  function automatic logic [4:0] bb_bit_mask(input logic [1:0] sz);
    logic [4:0] m;
    case (sz)
      2'd0:    m = 5'h07;
      2'd1:    m = 5'h0F;
      default: m = 5'h1F;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
  import bb_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter int              OFFS_W = 25,
  parameter int              BIT_W  = 5,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [OFFS_W-1:0] offset,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [BIT_W-1:0]  bit_idx
);
  // One alias word (4 bytes) per backing bit, 8 bits per byte: shift by 5.
  localparam int SHIFT = 5;
  localparam int SEL_W = OFFS_W - SHIFT;

  logic [ADDR_W-1:0] sel;
  logic [ADDR_W-1:0] raw;
  logic              unused_lo;

  assign sel       = {{(ADDR_W-SEL_W){1'b0}}, offset[OFFS_W-1:SHIFT]};
  assign raw       = BASE | sel;
  assign phys_addr = {raw[ADDR_W-1:2], raw[1:0] & bb_keep_low(size)};
  assign bit_idx   = offset[BIT_W+1:2] & bb_bit_mask(size);
  assign unused_lo = ^offset[1:0];

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int DATA_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic [DATA_W-1:0] unit_in,
  input  logic [BIT_W-1:0]  idx,
  input  logic              set_val,
  output logic              pick,
  output logic [DATA_W-1:0] merged
);
  assign pick = unit_in[idx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = (BIT_W'(i) == idx) ? set_val : unit_in[i];
  end

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_req,
  input  logic              s_we,
  input  logic              size_legal,
  input  logic              m_ready,
  input  logic              m_err,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [DATA_W-1:0] merged,
  input  logic              pick_bit,
  output bb_state_e         state,
  output logic              accept,
  output logic              rd_done,
  output logic              rd_fault,
  output logic              wr_done,
  output logic              modify_ev,
  output logic [DATA_W-1:0] unit_q,
  output logic              m_req,
  output logic              m_we,
  output logic              s_ready,
  output logic              s_err,
  output logic [DATA_W-1:0] s_rdata
);
  bb_state_e nxt;
  logic      we_q;
  logic      err_q;
  logic      bit_q;

  assign accept    = (state == BB_IDLE) && s_req;
  assign rd_done   = (state == BB_READ) && m_ready;
  assign rd_fault  = rd_done && m_err;
  assign wr_done   = (state == BB_WRITE) && m_ready;
  assign modify_ev = (state == BB_MODIFY);

  always_comb begin
    nxt = state;
    case (state)
      BB_IDLE:   if (accept) nxt = size_legal ? BB_READ : BB_RESP;
      BB_READ:   if (m_ready) nxt = (m_err || !we_q) ? BB_RESP : BB_MODIFY;
      BB_MODIFY: nxt = BB_WRITE;
      BB_WRITE:  if (m_ready) nxt = BB_RESP;
      BB_RESP:   nxt = BB_IDLE;
      default:   nxt = BB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= BB_IDLE;
      we_q   <= 1'b0;
      err_q  <= 1'b0;
      bit_q  <= 1'b0;
      unit_q <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        we_q  <= s_we;
        err_q <= !size_legal;
        bit_q <= 1'b0;
      end
      if (rd_done) begin
        err_q  <= m_err;
        unit_q <= m_rdata;
        if (!m_err && !we_q) bit_q <= pick_bit;
      end
      if (modify_ev) unit_q <= merged;
      if (wr_done) err_q <= m_err;
    end
  end

  assign m_req   = (state == BB_READ) || (state == BB_WRITE);
  assign m_we    = (state == BB_WRITE);
  assign s_ready = (state == BB_RESP);
  assign s_err   = s_ready && err_q;
  assign s_rdata = {{(DATA_W-1){1'b0}}, bit_q};

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter int                OFFS_W = 25,
  parameter int                DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_req,
  input  logic              s_we,
  input  logic [1:0]        s_size,
  input  logic [OFFS_W-1:0] s_offset,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_ready,
  output logic              s_err,
  output logic [DATA_W-1:0] s_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [1:0]        m_size,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_ready,
  input  logic              m_err,
  input  logic [DATA_W-1:0] m_rdata
);
  localparam int BIT_W = $clog2(DATA_W);

  bb_state_e         state;
  logic              accept, rd_done, rd_fault, wr_done, modify_ev;
  logic [1:0]        size_q;
  logic [OFFS_W-1:0] off_q;
  logic              wbit_q;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] unit_q, unit_src, merged;
  logic              pick_bit;
  logic              size_legal;
  logic              unused_wdata;

  assign size_legal   = bb_size_legal(s_size);
  assign unused_wdata = ^s_wdata[DATA_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      off_q  <= '0;
      wbit_q <= 1'b0;
    end else if (accept) begin
      size_q <= s_size;
      off_q  <= s_offset;
      wbit_q <= s_wdata[0];
    end
  end

  bb_addr_map #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BIT_W(BIT_W), .BASE(BASE)
  ) u_map (
    .offset   (off_q),
    .size     (size_q),
    .phys_addr(m_addr),
    .bit_idx  (bit_idx)
  );

  assign unit_src = (state == BB_READ) ? m_rdata : unit_q;

  bb_bit_merge #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_merge (
    .unit_in(unit_src),
    .idx    (bit_idx),
    .set_val(wbit_q),
    .pick   (pick_bit),
    .merged (merged)
  );

  bb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_req     (s_req),
    .s_we      (s_we),
    .size_legal(size_legal),
    .m_ready   (m_ready),
    .m_err     (m_err),
    .m_rdata   (m_rdata),
    .merged    (merged),
    .pick_bit  (pick_bit),
    .state     (state),
    .accept    (accept),
    .rd_done   (rd_done),
    .rd_fault  (rd_fault),
    .wr_done   (wr_done),
    .modify_ev (modify_ev),
    .unit_q    (unit_q),
    .m_req     (m_req),
    .m_we      (m_we),
    .s_ready   (s_ready),
    .s_err     (s_err),
    .s_rdata   (s_rdata)
  );

  assign m_size  = size_q;
  assign m_wdata = unit_q;

endmodule

// File: rtl/bb_bridge_chk.sv
module bb_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_req,
  input logic              m_we,
  input logic              m_ready,
  input logic              m_err,
  input logic [1:0]        m_size,
  input logic [ADDR_W-1:0] m_addr,
  input logic              s_ready,
  input logic              s_err,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_size,
  input logic              accept,
  input logic              rd_fault,
  input logic              modify_ev
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ready |=> m_req && $stable(m_addr) && $stable(m_we));

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  a_r1_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && (m_size == 2'd2) |-> (m_addr[1:0] == 2'b00));

  a_r1_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && (m_size == 2'd1) |-> (m_addr[0] == 1'b0));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (s_rdata[DATA_W-1:1] == '0));

  a_r6_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |=> !m_req && s_ready && s_err);

  a_r7_wb_fault: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_we && m_ready && m_err |=> s_ready && s_err);

  a_r5_wb_after_modify: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req && m_we) |-> $past(modify_ev));

  a_r2_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (s_size == 2'd3) |=> !m_req && s_ready && s_err);

endmodule

bind bitband_bridge bb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_req    (m_req),
  .m_we     (m_we),
  .m_ready  (m_ready),
  .m_err    (m_err),
  .m_size   (m_size),
  .m_addr   (m_addr),
  .s_ready  (s_ready),
  .s_err    (s_err),
  .s_rdata  (s_rdata),
  .s_size   (s_size),
  .accept   (accept),
  .rd_fault (rd_fault),
  .modify_ev(modify_ev)
);

// File: tb/bitband_bridge_tb_top.sv
`timescale 1ns/1ps
module bitband_bridge_tb_top;
  localparam logic [31:0] BASE_A = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_req, s_we;
  logic [1:0]  s_size;
  logic [24:0] s_offset;
  logic [31:0] s_wdata;
  logic        s_ready, s_err;
  logic [31:0] s_rdata;
  logic        m_req, m_we;
  logic [1:0]  m_size;
  logic [31:0] m_addr, m_wdata;
  logic        m_ready, m_err;
  logic [31:0] m_rdata;

  always #2.5 clk = ~clk;

  bitband_bridge #(.BASE(BASE_A)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_req(s_req), .s_we(s_we), .s_size(s_size), .s_offset(s_offset),
    .s_wdata(s_wdata), .s_ready(s_ready), .s_err(s_err), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata)
  );

  typedef struct {
    string       req;
    logic [31:0] rdata;
    logic        err;
    logic        bad;
    logic        chk_wr;
    logic [31:0] addr;
    logic [1:0]  size;
    int          rd_cnt;
    int          wr_cnt;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  mem [0:255];
  int          n_chk = 0, n_bad = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [1:0]  last_size = '0;
  int          lat = 0;
  logic        wr_fail = 1'b0;
  logic        done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Backing memory responder; indices 0xE0..0xFF answer reads with a fault.
  initial begin
    int         wait_cnt;
    int         nb;
    logic [7:0] idx;
    logic [31:0] d;
    wait_cnt = 0;
    m_ready = 1'b0; m_err = 1'b0; m_rdata = '0;
    forever begin
      @(negedge clk);
      if (m_ready) begin
        m_ready = 1'b0; m_err = 1'b0; wait_cnt = 0;
      end else if (m_req) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          nb  = 1 << m_size;
          idx = m_addr[7:0];
          if (!m_we) begin
            rd_cnt++;
            last_rd_addr = m_addr;
            last_size    = m_size;
            d = '0;
            for (int k = 0; k < 4; k++)
              if (k < nb) d[8*k +: 8] = mem[idx + 8'(k)];
            m_rdata = d;
            m_err   = (idx >= 8'hE0);
          end else begin
            wr_cnt++;
            last_wr_addr = m_addr;
            m_err = wr_fail;
            if (!wr_fail)
              for (int k = 0; k < 4; k++)
                if (k < nb) mem[idx + 8'(k)] = m_wdata[8*k +: 8];
          end
          m_ready = 1'b1;
        end
      end
    end
  end

  // Monitor: pops one expected item per completion.
  initial begin
    logic prev;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (s_ready && prev) chk("R8", "ready pulse width", 32'd2, 32'd1);
      prev = s_ready;
      if (s_ready) begin
        if (exp_q.size() == 0) chk("R8", "unexpected completion", 32'd1, 32'd0);
        else begin
          e = exp_q.pop_front();
          chk(e.req, "read data", s_rdata, e.rdata);
          chk(e.req, "error flag", 32'(s_err), 32'(e.err));
          chk("R8", "backing reads done", 32'(rd_cnt), 32'(e.rd_cnt));
          chk("R8", "backing writes done", 32'(wr_cnt), 32'(e.wr_cnt));
          if (!e.bad) begin
            chk("R1", "backing address", last_rd_addr, e.addr);
            chk("R1", "backing size", 32'(last_size), 32'(e.size));
          end
          if (e.chk_wr) chk("R5", "write-back address", last_wr_addr, e.addr);
        end
      end
    end
  end

  // Driver: computes the expectation, pushes it, runs the access.
  task automatic access(input logic we, input logic [1:0] sz, input logic [24:0] off,
                        input logic [31:0] wd, input string req);
    exp_t       e;
    int         idx, bp;
    logic [7:0] old_b, new_b;
    logic       bad, rerr;
    idx   = int'(off >> 5);
    bp    = int'(off[4:2]);
    bad   = (sz == 2'd3);
    rerr  = !bad && (idx >= 224);
    old_b = mem[idx];
    new_b = old_b;
    new_b[bp] = wd[0];
    e.req    = req;
    e.bad    = bad;
    e.size   = sz;
    e.addr   = (BASE_A + 32'(idx)) & ~((32'd1 << sz) - 32'd1);
    e.rdata  = (!we && !bad && !rerr) ? {31'b0, old_b[bp]} : 32'd0;
    e.err    = bad || rerr || (we && wr_fail);
    e.chk_wr = we && !bad && !rerr;
    e.rd_cnt = rd_cnt + (bad ? 0 : 1);
    e.wr_cnt = wr_cnt + (e.chk_wr ? 1 : 0);
    exp_q.push_back(e);
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_size = sz; s_offset = off; s_wdata = wd;
    forever begin
      @(negedge clk);
      if (s_ready) break;
    end
    s_req = 1'b0;
    if (we) chk(req, "backing byte", 32'(mem[idx]), 32'(e.err ? old_b : new_b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    rst_n = 1'b0; s_req = 1'b0; s_we = 1'b0; s_size = '0; s_offset = '0; s_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9", "m_req in reset", 32'(m_req), 32'd0);
    chk("R9", "s_ready in reset", 32'(s_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "m_req after reset", 32'(m_req), 32'd0);
    chk("R9", "s_err after reset", 32'(s_err), 32'd0);

    // Reads across sizes and bit positions (R1, R3, R4).
    access(1'b0, 2'd2, 25'h0044, 32'h0, "R3");
    access(1'b0, 2'd1, 25'h0A6C, 32'h0, "R3");
    access(1'b0, 2'd0, 25'h1234, 32'h0, "R4");
    access(1'b0, 2'd2, 25'h1BFC, 32'h0, "R1");
    // Writes: set, clear, upper data bits ignored (R5, R10).
    access(1'b1, 2'd0, 25'h0100, 32'h1, "R5");
    access(1'b0, 2'd2, 25'h0100, 32'h0, "R5");
    access(1'b1, 2'd2, 25'h0124, 32'h0, "R5");
    access(1'b1, 2'd1, 25'h0368, 32'h1, "R10");
    access(1'b1, 2'd1, 25'h0368, 32'hFFFF_FFFE, "R10");
    access(1'b0, 2'd0, 25'h0368, 32'h0, "R10");
    // Read fault, alone and during a write (R6).
    lat = 2;
    access(1'b0, 2'd2, 25'h1C04, 32'h0, "R6");
    access(1'b1, 2'd1, 25'h1D10, 32'h1, "R6");
    access(1'b1, 2'd0, 25'h1FFC, 32'h0, "R6");
    // Write-back fault (R7).
    wr_fail = 1'b1;
    access(1'b1, 2'd2, 25'h0200, 32'h1, "R7");
    wr_fail = 1'b0;
    access(1'b0, 2'd2, 25'h0200, 32'h0, "R7");
    // Illegal size (R2).
    access(1'b0, 2'd3, 25'h0040, 32'h0, "R2");
    access(1'b1, 2'd3, 25'h0040, 32'h1, "R2");
    // Mixed sweep with varied latency.
    for (int i = 0; i < 40; i++) begin
      lat = i % 4;
      access(i[0], 2'(i % 3), 25'((i * 389 + 7) & 32'h1BFF), 32'(i * 13),
             (i % 2) ? "R5" : "R4");
    end
    repeat (3) @(negedge clk);
    chk("R8", "pending responses", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule